// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block holds the first sixteen dwords (64 bytes) of a single-function PCI type-0 configuration header. It is fed by the configuration transaction path of a PCI target. That path has already decided the device is addressed. It hands over a dword register number, the bus command, the byte enables and the write data for one cycle. A Configuration Write updates the writable fields. A Configuration Read returns the addressed dword one clock later.

The identity fields and the fixed layout bytes come from parameters: vendor, device, class, revision, subsystem, header type, interrupt pin, MIN_GNT, MAX_LAT and the capabilities pointer. The block drives the programmed BAR and expansion ROM bases to the address decoder. It drives the command-register enables to the bus engines and to the parity logic. Error events from those engines set sticky status bits, and software clears them by writing ones.

Top module: `cfg_hdr_regs`

## Requirements
- R1: After reset the command register, status error bits, all BAR and ROM bases, Cache Line Size, Latency Timer and Interrupt Line are zero, and `cfg_rvalid_o` and `cfg_rdata_o` are zero.
- R2: Dword 0 reads {Device ID, Vendor ID}, dword 2 reads {Class Code, Revision ID} and dword 11 reads {Subsystem ID, Subsystem Vendor ID`}`. All three come from parameters, and writes to them have no effect.
- R3: Dwords 4 to 9 are BAR0 to BAR5. A write updates only the bytes whose enable is set. It then forces every bit below the BAR's window size (2^log2, log2 of 4..31) to zero. A BAR with log2 of 0 always reads zero. `bar_base_o[32k+31:32k]` always equals the value read from BARk.
- R4: Dword 12 is the expansion ROM BAR. Bit 0 (enable) and the bits at and above the ROM window log2 are writable, and all other bits read zero. `rom_base_o` equals the value read.
- R5: Dword 1 bits 15:0 form the command register. Only bits 0 (I/O enable), 1 (memory enable), 2 (bus master), 6 (parity error response) and 8 (SERR enable) are writable, and the other bits read zero. The five outputs follow these bits.
- R6: Dword 1 bits 31:16 form the status register. Bit 4 reads 1 when the capabilities pointer parameter is non-zero. Error bits 8, 11, 12, 13, 14 and 15 are set by `sts_set_i[0..5]` in that order. They are cleared by writing 1 to them with the matching byte enable, and a set in the same cycle wins over a clear.
- R7: Dwords 10, 13 (bits 31:8), 14 and the BIST byte (dword 3 bits 31:24) read zero, and writing them has no effect.
- R8: A read is a request with command 4'b1010, and it gives `cfg_rvalid_o`=1 with the data on the following cycle. A write uses command 4'b1011. Any other command neither reads nor writes, and `cfg_rvalid_o` is 0 in every cycle that does not follow a read.
- R9: Dword 3 holds Cache Line Size (bits 7:0, writable), Latency Timer (bits 15:8, writable) and Header Type (bits 23:16, fixed). Dword 15 holds Interrupt Line (bits 7:0, writable), Interrupt Pin, MIN_GNT and MAX_LAT (bits 15:8, 23:16 and 31:24, fixed). Dword 13 bits 7:0 hold the capabilities pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_req_i | input | 1 | Configuration access valid this cycle |
| cfg_cmd_i | input | 4 | Bus command code |
| cfg_reg_i | input | 4 | Dword register number |
| cfg_be_i | input | 4 | Byte enables, active high |
| cfg_wdata_i | input | 32 | Write data |
| sts_set_i | input | 6 | Status error set pulses |
| cfg_rdata_o | output | 32 | Read data, held until the next read |
| cfg_rvalid_o | output | 1 | Read data valid |
| bar_base_o | output | 192 | Six BAR values, BAR0 in the low bits |
| rom_base_o | output | 32 | Expansion ROM BAR value |
| io_en_o | output | 1 | Command bit 0 |
| mem_en_o | output | 1 | Command bit 1 |
| bus_master_o | output | 1 | Command bit 2 |
| perr_resp_o | output | 1 | Command bit 6 |
| serr_en_o | output | 1 | Command bit 8 |

## Verification
A corrupted BAR, ROM or command bit reaches the ports in the cycle after the write that caused it, because `bar_base_o`, `rom_base_o` and the enables are compared against the reference on every clock. A wrong status bit, a stuck writable byte or a bad read-mux entry shows up only on the next read of that dword, one clock after the request. For that reason the sequence reads back every dword after each group of writes. A read strobe that fires on the wrong command shows up at once as a `cfg_rvalid_o` mismatch.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int unsigned NBAR      = 6;
  localparam int unsigned DW        = 32;
  localparam int unsigned BAR_FIRST = 4;
  localparam logic [3:0]  REG_ID    = 4'h0;
  localparam logic [3:0]  REG_CMDST = 4'h1;
  localparam logic [3:0]  REG_CLASS = 4'h2;
  localparam logic [3:0]  REG_MISC  = 4'h3;
  localparam logic [3:0]  REG_SUBID = 4'hB;
  localparam logic [3:0]  REG_ROM   = 4'hC;
  localparam logic [3:0]  REG_CAP   = 4'hD;
  localparam logic [3:0]  REG_INT   = 4'hF;

  typedef enum logic [3:0] {
    CMD_CFG_RD = 4'b1010,
    CMD_CFG_WR = 4'b1011
  } cfg_cmd_e;

  localparam logic [15:0] CMD_WMASK = 16'h0147;
  localparam logic [15:0] STS_EMASK = 16'hF900;

  function automatic logic [31:0] be_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [15:0] sts_expand(input logic [5:0] s);
    return {s[5], s[4], s[3], s[2], s[1], 2'b00, s[0], 8'h00};
  endfunction
endpackage

// File: rtl/cfg_bar_reg.sv
module cfg_bar_reg #(
  parameter int unsigned ADDR_LOG2 = 12,
  parameter bit          IS_ROM    = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] val_o
);
  import cfg_hdr_pkg::*;

  localparam logic [31:0] ADDR_KEEP = (ADDR_LOG2 == 0) ? 32'h0
                                    : ~((32'd1 << ADDR_LOG2) - 32'd1);
  localparam logic [31:0] KEEP = (IS_ROM && ADDR_LOG2 != 0) ? (ADDR_KEEP | 32'h1)
                                                            : ADDR_KEEP;

  logic [31:0] val_q;
  logic [31:0] merged;

  always_comb begin
    merged = (val_q & ~be_mask(be_i)) | (wdata_i & be_mask(be_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   val_q <= '0;
    else if (we_i) val_q <= merged & KEEP;
  end

  assign val_o = val_q;
endmodule

// File: rtl/cfg_cmd_sts.sv
module cfg_cmd_sts #(
  parameter bit CAP_EN = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  input  logic [5:0]  sts_set_i,
  output logic [15:0] cmd_o,
  output logic [15:0] sts_o
);
  import cfg_hdr_pkg::*;

  logic [15:0] cmd_q, err_q;
  logic [31:0] wmask;
  logic [15:0] err_clr, err_set;

  assign wmask   = be_mask(be_i) & {32{we_i}};
  assign err_clr = wdata_i[31:16] & wmask[31:16] & STS_EMASK;
  assign err_set = sts_expand(sts_set_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      err_q <= '0;
    end else begin
      cmd_q <= ((cmd_q & ~wmask[15:0]) | (wdata_i[15:0] & wmask[15:0])) & CMD_WMASK;
      err_q <= (err_q & ~err_clr) | err_set;
    end
  end

  assign cmd_o = cmd_q;
  assign sts_o = err_q | {11'h0, CAP_EN, 4'h0};
endmodule

// File: rtl/cfg_hdr_regs.sv
module cfg_hdr_regs
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'h1D0F,
  parameter logic [15:0] DEVICE_ID   = 16'h7A31,
  parameter logic [7:0]  REVISION_ID = 8'h03,
  parameter logic [23:0] CLASS_CODE  = 24'h058000,
  parameter logic [7:0]  HEADER_TYPE = 8'h00,
  parameter logic [15:0] SUBSYS_VID  = 16'h1D0F,
  parameter logic [15:0] SUBSYS_ID   = 16'h0042,
  parameter logic [7:0]  CAP_PTR     = 8'h40,
  parameter logic [7:0]  INT_PIN     = 8'h01,
  parameter logic [7:0]  MIN_GNT     = 8'h04,
  parameter logic [7:0]  MAX_LAT     = 8'h18,
  parameter int unsigned BAR_LOG2 [NBAR] = '{12, 20, 0, 16, 4, 0},
  parameter int unsigned ROM_LOG2 = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_req_i,
  input  logic [3:0]           cfg_cmd_i,
  input  logic [3:0]           cfg_reg_i,
  input  logic [3:0]           cfg_be_i,
  input  logic [31:0]          cfg_wdata_i,
  input  logic [5:0]           sts_set_i,
  output logic [31:0]          cfg_rdata_o,
  output logic                 cfg_rvalid_o,
  output logic [NBAR*DW-1:0]   bar_base_o,
  output logic [31:0]          rom_base_o,
  output logic                 io_en_o,
  output logic                 mem_en_o,
  output logic                 bus_master_o,
  output logic                 perr_resp_o,
  output logic                 serr_en_o
);
  logic        is_rd, is_wr;
  logic [31:0] wmask;
  logic [31:0] bar_val [NBAR];
  logic [31:0] rom_val;
  logic [15:0] cmd_val, sts_val;
  logic [7:0]  cls_q, lat_q, intl_q;
  logic [31:0] rd_next, rdata_q;
  logic        rvalid_q;

  assign is_rd = cfg_req_i && (cfg_cmd_i == CMD_CFG_RD);
  assign is_wr = cfg_req_i && (cfg_cmd_i == CMD_CFG_WR);
  assign wmask = be_mask(cfg_be_i);

  for (genvar g = 0; g < NBAR; g++) begin : g_bar
    cfg_bar_reg #(.ADDR_LOG2(BAR_LOG2[g]), .IS_ROM(1'b0)) u_bar (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (is_wr && cfg_reg_i == 4'(BAR_FIRST + g)),
      .be_i    (cfg_be_i),
      .wdata_i (cfg_wdata_i),
      .val_o   (bar_val[g])
    );
    assign bar_base_o[g*DW +: DW] = bar_val[g];
  end

  cfg_bar_reg #(.ADDR_LOG2(ROM_LOG2), .IS_ROM(1'b1)) u_rom (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (is_wr && cfg_reg_i == REG_ROM),
    .be_i    (cfg_be_i),
    .wdata_i (cfg_wdata_i),
    .val_o   (rom_val)
  );

  cfg_cmd_sts #(.CAP_EN(CAP_PTR != 8'h00)) u_cmdst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (is_wr && cfg_reg_i == REG_CMDST),
    .be_i      (cfg_be_i),
    .wdata_i   (cfg_wdata_i),
    .sts_set_i (sts_set_i),
    .cmd_o     (cmd_val),
    .sts_o     (sts_val)
  );

  // writable bytes of the misc and interrupt dwords
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_q  <= '0;
      lat_q  <= '0;
      intl_q <= '0;
    end else if (is_wr) begin
      if (cfg_reg_i == REG_MISC && wmask[0])  cls_q  <= cfg_wdata_i[7:0];
      if (cfg_reg_i == REG_MISC && wmask[8])  lat_q  <= cfg_wdata_i[15:8];
      if (cfg_reg_i == REG_INT  && wmask[0])  intl_q <= cfg_wdata_i[7:0];
    end
  end

  always_comb begin
    rd_next = '0;
    case (cfg_reg_i)
      REG_ID:    rd_next = {DEVICE_ID, VENDOR_ID};
      REG_CMDST: rd_next = {sts_val, cmd_val};
      REG_CLASS: rd_next = {CLASS_CODE, REVISION_ID};
      REG_MISC:  rd_next = {8'h00, HEADER_TYPE, lat_q, cls_q};
      REG_SUBID: rd_next = {SUBSYS_ID, SUBSYS_VID};
      REG_ROM:   rd_next = rom_val;
      REG_CAP:   rd_next = {24'h0, CAP_PTR};
      REG_INT:   rd_next = {MAX_LAT, MIN_GNT, INT_PIN, intl_q};
      default:   rd_next = '0;
    endcase
    for (int k = 0; k < NBAR; k++) begin
      if (cfg_reg_i == 4'(BAR_FIRST + k)) rd_next = bar_val[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= is_rd;
      if (is_rd) rdata_q <= rd_next;
    end
  end

  assign cfg_rdata_o  = rdata_q;
  assign cfg_rvalid_o = rvalid_q;
  assign rom_base_o   = rom_val;
  assign io_en_o      = cmd_val[0];
  assign mem_en_o     = cmd_val[1];
  assign bus_master_o = cmd_val[2];
  assign perr_resp_o  = cmd_val[6];
  assign serr_en_o    = cmd_val[8];
endmodule

// File: rtl/cfg_hdr_chk.sv
module cfg_hdr_chk
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VID = 16'h0,
  parameter logic [15:0] DID = 16'h0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_req_i,
  input logic [3:0]        cfg_cmd_i,
  input logic [3:0]        cfg_reg_i,
  input logic [31:0]       cfg_rdata_o,
  input logic              cfg_rvalid_o,
  input logic [NBAR*DW-1:0] bar_base_o,
  input logic [31:0]       rom_base_o,
  input logic              io_en_o,
  input logic              mem_en_o,
  input logic              bus_master_o,
  input logic              perr_resp_o,
  input logic              serr_en_o
);
  logic rd_req, wr_req;
  assign rd_req = cfg_req_i && cfg_cmd_i == CMD_CFG_RD;
  assign wr_req = cfg_req_i && cfg_cmd_i == CMD_CFG_WR;

  p_rvalid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> cfg_rvalid_o);
  p_no_rvalid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !cfg_rvalid_o);
  p_id_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && cfg_reg_i == REG_ID) |=> cfg_rdata_o == {DID, VID});
  p_rsvd_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && cfg_reg_i == 4'hA) |=> cfg_rdata_o == 32'h0);
  p_bar_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_req |=> ($stable(bar_base_o) && $stable(rom_base_o)));
  p_cmd_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_req && cfg_reg_i == REG_CMDST) |=>
      $stable({io_en_o, mem_en_o, bus_master_o, perr_resp_o, serr_en_o}));
endmodule

bind cfg_hdr_regs cfg_hdr_chk #(.VID(VENDOR_ID), .DID(DEVICE_ID)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_req_i    (cfg_req_i),
  .cfg_cmd_i    (cfg_cmd_i),
  .cfg_reg_i    (cfg_reg_i),
  .cfg_rdata_o  (cfg_rdata_o),
  .cfg_rvalid_o (cfg_rvalid_o),
  .bar_base_o   (bar_base_o),
  .rom_base_o   (rom_base_o),
  .io_en_o      (io_en_o),
  .mem_en_o     (mem_en_o),
  .bus_master_o (bus_master_o),
  .perr_resp_o  (perr_resp_o),
  .serr_en_o    (serr_en_o)
);

// File: tb/tb_cfg_hdr_regs.sv
`timescale 1ns/1ps
module tb_cfg_hdr_regs;
  localparam logic [15:0] T_VID  = 16'hA5C3;
  localparam logic [15:0] T_DID  = 16'h3C5A;
  localparam logic [7:0]  T_REV  = 8'h11;
  localparam logic [23:0] T_CLS  = 24'h0C0330;
  localparam logic [7:0]  T_HDR  = 8'h00;
  localparam logic [15:0] T_SVID = 16'h1234;
  localparam logic [15:0] T_SID  = 16'h5678;
  localparam logic [7:0]  T_CAP  = 8'h48;
  localparam logic [7:0]  T_PIN  = 8'h02;
  localparam logic [7:0]  T_MING = 8'h07;
  localparam logic [7:0]  T_MAXL = 8'h21;
  localparam int unsigned T_BL [6] = '{12, 20, 0, 16, 4, 31};
  localparam int unsigned T_RL = 17;

  logic clk = 0, rst_n = 0;
  logic req = 0;
  logic [3:0] cmd = 0, rg = 0, be = 0;
  logic [31:0] wd = 0;
  logic [5:0] sset = 0;
  logic [31:0] rdata, rom_base;
  logic rvalid, io_en, mem_en, bm_en, perr_en, serr_en;
  logic [191:0] bar_base;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  cfg_hdr_regs #(
    .VENDOR_ID(T_VID), .DEVICE_ID(T_DID), .REVISION_ID(T_REV), .CLASS_CODE(T_CLS),
    .HEADER_TYPE(T_HDR), .SUBSYS_VID(T_SVID), .SUBSYS_ID(T_SID), .CAP_PTR(T_CAP),
    .INT_PIN(T_PIN), .MIN_GNT(T_MING), .MAX_LAT(T_MAXL), .BAR_LOG2(T_BL), .ROM_LOG2(T_RL)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_req_i(req), .cfg_cmd_i(cmd), .cfg_reg_i(rg),
    .cfg_be_i(be), .cfg_wdata_i(wd), .sts_set_i(sset), .cfg_rdata_o(rdata),
    .cfg_rvalid_o(rvalid), .bar_base_o(bar_base), .rom_base_o(rom_base),
    .io_en_o(io_en), .mem_en_o(mem_en), .bus_master_o(bm_en),
    .perr_resp_o(perr_en), .serr_en_o(serr_en)
  );

  // reference model
  logic [31:0] m_bar [6];
  logic [31:0] m_rom, m_rdata;
  logic [15:0] m_cmd, m_sts;
  logic [7:0]  m_cls, m_lat, m_il;
  logic        m_rvalid;

  function automatic logic [31:0] bmask(input logic [3:0] b);
    logic [31:0] m = 0;
    for (int i = 0; i < 4; i++) if (b[i]) m[i*8 +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [31:0] keep_of(input int unsigned l2);
    if (l2 == 0) return 32'h0;
    return 32'hFFFF_FFFF << l2;
  endfunction

  function automatic logic [31:0] m_read(input int r);
    if (r >= 4 && r <= 9) return m_bar[r-4];
    case (r)
      0:  return {T_DID, T_VID};
      1:  return {m_sts | ((T_CAP != 0) ? 16'h0010 : 16'h0), m_cmd};
      2:  return {T_CLS, T_REV};
      3:  return {8'h00, T_HDR, m_lat, m_cls};
      11: return {T_SID, T_SVID};
      12: return m_rom;
      13: return {24'h0, T_CAP};
      15: return {T_MAXL, T_MING, T_PIN, m_il};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) m_bar[i] <= 0;
      m_rom <= 0; m_cmd <= 0; m_sts <= 0; m_cls <= 0; m_lat <= 0; m_il <= 0;
      m_rdata <= 0; m_rvalid <= 0;
    end else begin
      logic [31:0] bm;
      logic [15:0] setv, clrv;
      bm = bmask(be);
      setv = 0;
      if (sset[0]) setv[8] = 1;
      for (int i = 1; i < 6; i++) if (sset[i]) setv[10+i] = 1;
      clrv = 0;
      m_rvalid <= req && cmd == 4'b1010;
      if (req && cmd == 4'b1010) m_rdata <= m_read(int'(rg));
      if (req && cmd == 4'b1011) begin
        if (rg >= 4 && rg <= 9)
          m_bar[rg-4] <= ((m_bar[rg-4] & ~bm) | (wd & bm)) & keep_of(T_BL[rg-4]);
        if (rg == 12)
          m_rom <= ((m_rom & ~bm) | (wd & bm)) & (keep_of(T_RL) | 32'h1);
        if (rg == 1) begin
          m_cmd <= ((m_cmd & ~bm[15:0]) | (wd[15:0] & bm[15:0])) & 16'h0147;
          clrv = wd[31:16] & bm[31:16] & 16'hF900;
        end
        if (rg == 3 && be[0]) m_cls <= wd[7:0];
        if (rg == 3 && be[1]) m_lat <= wd[15:8];
        if (rg == 15 && be[0]) m_il <= wd[7:0];
      end
      m_sts <= (m_sts & ~clrv) | setv;
    end
  end

  task automatic chk(input string what, input logic [191:0] act, input logic [191:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("rvalid", 192'(rvalid), 192'(m_rvalid));
      chk("rdata", 192'(rdata), 192'(m_rdata));
      chk("cmd enables", 192'({io_en, mem_en, bm_en, perr_en, serr_en}),
          192'({m_cmd[0], m_cmd[1], m_cmd[2], m_cmd[6], m_cmd[8]}));
      chk("bar_base", bar_base, {m_bar[5], m_bar[4], m_bar[3], m_bar[2], m_bar[1], m_bar[0]});
      chk("rom_base", 192'(rom_base), 192'(m_rom));
    end
  end

  task automatic op(input logic [3:0] c, input logic [3:0] r, input logic [3:0] b,
                    input logic [31:0] d);
    @(negedge clk);
    req = 1; cmd = c; rg = r; be = b; wd = d;
    @(negedge clk);
    req = 0; be = 0; wd = 0;
  endtask

  task automatic wr(input logic [3:0] r, input logic [3:0] b, input logic [31:0] d);
    op(4'b1011, r, b, d);
  endtask

  task automatic rd(input logic [3:0] r);
    op(4'b1010, r, 4'hF, 32'h0);
  endtask

  task automatic read_all();
    for (int r = 0; r < 16; r++) rd(4'(r));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 50000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cur = "R1";
    chk("reset rdata", 192'(rdata), 192'h0);
    chk("reset rvalid", 192'(rvalid), 192'h0);
    rst_n = 1;
    read_all();

    cur = "R2";
    wr(4'h0, 4'hF, 32'hFFFF_FFFF); wr(4'h2, 4'hF, 32'hFFFF_FFFF); wr(4'hB, 4'hF, 32'h0);
    rd(4'h0); rd(4'h2); rd(4'hB);

    cur = "R3";
    for (int r = 4; r <= 9; r++) begin wr(4'(r), 4'hF, 32'hFFFF_FFFF); rd(4'(r)); end
    wr(4'h4, 4'b0100, 32'h0000_0000); rd(4'h4);
    wr(4'h5, 4'b1001, 32'h1234_5678); rd(4'h5);
    wr(4'h8, 4'hF, 32'h0000_00F0); rd(4'h8);
    for (int r = 4; r <= 9; r++) begin wr(4'(r), 4'hF, 32'hDEAD_BEEF); rd(4'(r)); end

    cur = "R4";
    wr(4'hC, 4'hF, 32'hFFFF_FFFF); rd(4'hC);
    wr(4'hC, 4'b0001, 32'h0000_0000); rd(4'hC);
    wr(4'hC, 4'hF, 32'h0002_0001); rd(4'hC);

    cur = "R5";
    wr(4'h1, 4'b0011, 32'h0000_FFFF); rd(4'h1);
    wr(4'h1, 4'b0001, 32'h0000_0040); rd(4'h1);
    wr(4'h1, 4'b0010, 32'h0000_0000); rd(4'h1);
    wr(4'h1, 4'b0011, 32'h0000_0146); rd(4'h1);

    cur = "R6";
    @(negedge clk); sset = 6'b111111; @(negedge clk); sset = 0;
    rd(4'h1);
    wr(4'h1, 4'b1000, 32'h8000_0000); rd(4'h1);
    wr(4'h1, 4'b0100, 32'hFFFF_0000); rd(4'h1);
    @(negedge clk);
    req = 1; cmd = 4'b1011; rg = 4'h1; be = 4'b1100; wd = 32'hFFFF_0146; sset = 6'b000101;
    @(negedge clk); req = 0; be = 0; wd = 0; sset = 0;
    rd(4'h1);
    wr(4'h1, 4'b1100, 32'hFFFF_0000); rd(4'h1);

    cur = "R7";
    wr(4'hA, 4'hF, 32'hFFFF_FFFF); wr(4'hD, 4'hF, 32'hFFFF_FFFF);
    wr(4'hE, 4'hF, 32'hFFFF_FFFF); wr(4'h3, 4'b1000, 32'hFF00_0000);
    rd(4'hA); rd(4'hD); rd(4'hE); rd(4'h3);

    cur = "R8";
    op(4'b0111, 4'h1, 4'hF, 32'h0000_0000); rd(4'h1);
    op(4'b0110, 4'h4, 4'hF, 32'h0);
    op(4'b0011, 4'h4, 4'hF, 32'h0); rd(4'h4);
    op(4'b1010, 4'h0, 4'hF, 32'h0); op(4'b1010, 4'hB, 4'hF, 32'h0);
    repeat (2) @(negedge clk);

    cur = "R9";
    wr(4'h3, 4'hF, 32'hFFA5_5AC3); rd(4'h3);
    wr(4'h3, 4'b0010, 32'h0000_1100); rd(4'h3);
    wr(4'hF, 4'hF, 32'hFFFF_FF3C); rd(4'hF);
    wr(4'hF, 4'b1110, 32'h0000_0000); rd(4'hF);
    read_all();

    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule